// File: doc/BRIEF.md
# Multi-lane 7:1 video deserializer

This block turns five serial data lanes into one 35-bit parallel word per pixel period and recovers a pixel clock for the parallel side. A sixth lane carries the forwarded pixel clock as a fixed 7-bit pattern. All six lanes are sampled by one bit-rate clock running at seven times the pixel rate. That clock stands in for the receiver's PLL. The pattern seen on the clock lane finds the word boundary. Data is released only after the boundary has been confirmed over several frames in a row.

On the output side the block models the receiver's control pins. An active-low power-down input forces zeros and holds the clock low. An output enable puts every output in high impedance and overrides power-down. An edge-select input chooses whether new words appear with the rising or the falling edge of the recovered clock. The block does not map the 35 bits onto color and sync fields; that is left to the consumer. A spare test input has no effect.

Top module: `vid_deser7`

## Requirements
- R1: After reset, with `oe_i` and `pd_ni` high, `data_o` is 0, `pclk_o` is low and `lock_o` is low.
- R2: Lane i fills `data_o[7*i+6 : 7*i]`, and the first bit a lane receives in a frame becomes that slice's most significant bit.
- R3: A frame boundary is found by hunting: it is the bit where the last 7 clock-lane bits, earliest first, read 1100011. No output edge is produced until that pattern is seen.
- R4: `lock_o` rises at the end of the 4th consecutive matching frame. While `lock_o` is low `data_o` is 0, so the first three frames after alignment come out as zero.
- R5: If a tracked frame's clock-lane pattern is not 1100011, then at its last bit `lock_o` falls, `data_o` goes to 0 and hunting restarts.
- R6: While aligned, `pclk_o` is high for 4 and low for 3 bit-clock periods. With `edge_sel_i` high, `data_o` takes the word just completed at the bit-clock edge where `pclk_o` rises.
- R7: With `edge_sel_i` low, `data_o` takes each completed word at the bit-clock edge where `pclk_o` falls, 4 bit periods after the frame ends.
- R8: With `oe_i` low, every bit of `data_en_o` and `pclk_en_o` is 0 and the matching outputs are high impedance, whatever `pd_ni` and `edge_sel_i` are. Internal lock is unaffected.
- R9: With `oe_i` high and `pd_ni` low, `data_o` is 0 and `pclk_o` is low at once. Alignment and `lock_o` clear at the next bit-clock edge.
- R10: `test_i` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate sampling clock, 7x pixel rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lane_i | input | 5 | Serial data lanes, one bit per bit period |
| clk_lane_i | input | 1 | Serial forwarded pixel-clock lane |
| pd_ni | input | 1 | Power-down, active low |
| oe_i | input | 1 | Output enable; low puts outputs in high impedance |
| edge_sel_i | input | 1 | 1: update on rising `pclk_o`; 0: on falling |
| test_i | input | 1 | Spare test input, no function |
| data_o | output | 35 | Recovered parallel word |
| pclk_o | output | 1 | Recovered pixel clock |
| lock_o | output | 1 | Framing confirmed over 4 frames |
| data_en_o | output | 35 | Per-bit drive enable of `data_o` |
| pclk_en_o | output | 1 | Drive enable of `pclk_o` |

## Verification
The bit counter and the framing state cannot be seen directly. If the counter slips, the recovered words come out rotated or mixed across lanes at the very next update edge. The clock high time also departs from 4 bit periods within one pixel period. If the consecutive-match count is wrong, `lock_o` changes one or more frames early or late. The forced-zero prefix then has the wrong length, which shows in the first words after alignment. A latching edge chosen wrongly shifts each word by four bit periods against `pclk_o`, which the per-edge comparison catches on the first word after lock.

// File: rtl/vd7_pkg.sv
package vd7_pkg;
  localparam logic [6:0] CLK_LANE_PAT = 7'b1100011;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } vd7_state_e;
endpackage

// File: rtl/vd7_lane_deser.sv
module vd7_lane_deser #(
  parameter int unsigned WORD_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[WORD_W-3:0], bit_i};
  end

  // word completed by the bit present this cycle, first bit in the MSB
  assign word_o = {sh_q, bit_i};
endmodule

// File: rtl/vd7_framer.sv
module vd7_framer
  import vd7_pkg::*;
#(
  parameter  int unsigned       WORD_W      = 7,
  parameter  int unsigned       LOCK_FRAMES = 4,
  parameter  logic [WORD_W-1:0] PAT         = CLK_LANE_PAT,
  localparam int unsigned       CNT_W       = $clog2(WORD_W),
  localparam int unsigned       HIT_W       = $clog2(LOCK_FRAMES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pd_ni,
  input  logic             clk_lane_i,
  output logic             cap_o,
  output logic             track_d_o,
  output logic [CNT_W-1:0] cnt_d_o,
  output logic             lock_d_o,
  output logic             lock_o
);
  logic [WORD_W-2:0] csh_q;
  logic [WORD_W-1:0] win;
  vd7_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [HIT_W-1:0]  hits_q, hits_d;
  logic              lock_q, lock_d;
  logic              hit, frame_end, cap;

  assign win       = {csh_q, clk_lane_i};
  assign hit       = (win == PAT);
  // while hunting every bit is a candidate boundary
  assign frame_end = (state_q == ST_TRACK) ? (cnt_q == CNT_W'(WORD_W - 1)) : 1'b1;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    hits_d  = hits_q;
    lock_d  = lock_q;
    cap     = 1'b0;
    if (!pd_ni) begin
      state_d = ST_HUNT;
      cnt_d   = '0;
      hits_d  = '0;
      lock_d  = 1'b0;
    end else if (frame_end) begin
      if (hit) begin
        state_d = ST_TRACK;
        cnt_d   = '0;
        cap     = 1'b1;
        if (state_q == ST_HUNT)                   hits_d = HIT_W'(1);
        else if (hits_q != HIT_W'(LOCK_FRAMES))   hits_d = hits_q + 1'b1;
        lock_d = (hits_d == HIT_W'(LOCK_FRAMES));
      end else if (state_q == ST_TRACK) begin
        state_d = ST_HUNT;
        cnt_d   = '0;
        hits_d  = '0;
        lock_d  = 1'b0;
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csh_q   <= '0;
      state_q <= ST_HUNT;
      cnt_q   <= '0;
      hits_q  <= '0;
      lock_q  <= 1'b0;
    end else begin
      csh_q   <= win[WORD_W-2:0];
      state_q <= state_d;
      cnt_q   <= cnt_d;
      hits_q  <= hits_d;
      lock_q  <= lock_d;
    end
  end

  assign cap_o     = cap;
  assign track_d_o = (state_d == ST_TRACK);
  assign cnt_d_o   = cnt_d;
  assign lock_d_o  = lock_d;
  assign lock_o    = lock_q;
endmodule

// File: rtl/vd7_out_stage.sv
module vd7_out_stage #(
  parameter  int unsigned WORD_W = 7,
  parameter  int unsigned OUT_W  = 35,
  localparam int unsigned CNT_W  = $clog2(WORD_W),
  localparam int unsigned HI_LEN = (WORD_W + 1) / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [OUT_W-1:0] word_i,
  input  logic             cap_i,
  input  logic             track_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  input  logic             lock_d_i,
  input  logic             edge_sel_i,
  output logic [OUT_W-1:0] data_o,
  output logic             pclk_o
);
  logic [OUT_W-1:0] hold_q, out_q;
  logic             pclk_q, pclk_d, fall_upd;

  assign pclk_d   = track_d_i && (cnt_d_i < CNT_W'(HI_LEN));
  assign fall_upd = track_d_i && (cnt_d_i == CNT_W'(HI_LEN));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      out_q  <= '0;
      pclk_q <= 1'b0;
    end else begin
      pclk_q <= pclk_d;
      if (cap_i) hold_q <= word_i;
      if (!lock_d_i)                    out_q <= '0;
      else if (edge_sel_i && cap_i)     out_q <= word_i;
      else if (!edge_sel_i && fall_upd) out_q <= hold_q;
    end
  end

  assign data_o = out_q;
  assign pclk_o = pclk_q;
endmodule

// File: rtl/vid_deser7.sv
module vid_deser7
  import vd7_pkg::*;
#(
  parameter  int unsigned       LANES       = 5,
  parameter  int unsigned       WORD_W      = 7,
  parameter  int unsigned       LOCK_FRAMES = 4,
  parameter  logic [WORD_W-1:0] FRAME_PAT   = CLK_LANE_PAT,
  localparam int unsigned       OUT_W       = LANES * WORD_W,
  localparam int unsigned       CNT_W       = $clog2(WORD_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_i,
  input  logic             clk_lane_i,
  input  logic             pd_ni,
  input  logic             oe_i,
  input  logic             edge_sel_i,
  input  logic             test_i,
  output logic [OUT_W-1:0] data_o,
  output logic             pclk_o,
  output logic             lock_o,
  output logic [OUT_W-1:0] data_en_o,
  output logic             pclk_en_o
);
  logic [OUT_W-1:0] word_all, out_q;
  logic             cap, track_d, lock_d, lock_q, pclk_q;
  logic [CNT_W-1:0] cnt_d;
  logic             unused_test;

  assign unused_test = test_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    vd7_lane_deser #(.WORD_W(WORD_W)) u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .bit_i  (lane_i[g]),
      .word_o (word_all[g*WORD_W +: WORD_W])
    );
  end

  vd7_framer #(
    .WORD_W      (WORD_W),
    .LOCK_FRAMES (LOCK_FRAMES),
    .PAT         (FRAME_PAT)
  ) u_framer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pd_ni      (pd_ni),
    .clk_lane_i (clk_lane_i),
    .cap_o      (cap),
    .track_d_o  (track_d),
    .cnt_d_o    (cnt_d),
    .lock_d_o   (lock_d),
    .lock_o     (lock_q)
  );

  vd7_out_stage #(
    .WORD_W (WORD_W),
    .OUT_W  (OUT_W)
  ) u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .word_i     (word_all),
    .cap_i      (cap),
    .track_d_i  (track_d),
    .cnt_d_i    (cnt_d),
    .lock_d_i   (lock_d),
    .edge_sel_i (edge_sel_i),
    .data_o     (out_q),
    .pclk_o     (pclk_q)
  );

  // pad drivers: enable overrides power-down, power-down forces zero
  for (genvar g = 0; g < OUT_W; g++) begin : g_pad
    assign data_en_o[g] = oe_i;
    assign data_o[g]    = data_en_o[g] ? (pd_ni & out_q[g]) : 1'bz;
  end

  assign pclk_en_o = oe_i;
  assign pclk_o    = pclk_en_o ? (pd_ni & pclk_q) : 1'bz;
  assign lock_o    = lock_q;
endmodule

// File: rtl/vd7_checker.sv
module vd7_checker #(
  parameter int unsigned OUT_W = 35
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pd_ni,
  input logic             oe_i,
  input logic             edge_sel_i,
  input logic             lock_o,
  input logic [OUT_W-1:0] data_o,
  input logic             pclk_o,
  input logic [OUT_W-1:0] data_en_o,
  input logic             pclk_en_o,
  input logic [OUT_W-1:0] out_q,
  input logic             pclk_q
);
  p_hiz_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |-> (data_en_o == '0) && !pclk_en_o);

  p_pd_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && !pd_ni) |-> (data_o == '0) && !pclk_o);

  p_pd_unlock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !lock_o);

  p_unlocked_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_i && !lock_o) |-> (data_o == '0));

  // R7 covered by the falling branch
  p_latch_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_ni && $past(pd_ni) && lock_o && $past(lock_o) && !$stable(out_q))
      |-> ($past(edge_sel_i) ? $rose(pclk_q) : $fell(pclk_q)));
endmodule

bind vid_deser7 vd7_checker #(.OUT_W(OUT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pd_ni      (pd_ni),
  .oe_i       (oe_i),
  .edge_sel_i (edge_sel_i),
  .lock_o     (lock_o),
  .data_o     (data_o),
  .pclk_o     (pclk_o),
  .data_en_o  (data_en_o),
  .pclk_en_o  (pclk_en_o),
  .out_q      (out_q),
  .pclk_q     (pclk_q)
);

// File: tb/vid_deser7_test.sv
`timescale 1ns/1ps
module vid_deser7_test;
  localparam int LANES = 5;
  localparam int WW    = 7;
  localparam int OUT_W = LANES * WW;
  localparam logic [WW-1:0] PAT  = 7'b1100011;
  localparam logic [OUT_W-1:0] HOLD = 35'h5_A5C3_3C96;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_ni, pd_ni, oe_i, edge_sel_i, test_i, clk_lane_i;
  logic [LANES-1:0] lane_i;
  wire  [OUT_W-1:0] data_o, data_en_o;
  wire              pclk_o, lock_o, pclk_en_o;

  vid_deser7 uut (
    .clk_i(clk), .rst_ni(rst_ni), .lane_i(lane_i), .clk_lane_i(clk_lane_i),
    .pd_ni(pd_ni), .oe_i(oe_i), .edge_sel_i(edge_sel_i), .test_i(test_i),
    .data_o(data_o), .pclk_o(pclk_o), .lock_o(lock_o),
    .data_en_o(data_en_o), .pclk_en_o(pclk_en_o)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [OUT_W-1:0] exp_q[$];
  string            tag_q[$];
  bit   mon_en = 1'b0;
  logic prev_pclk = 1'b0;
  int   hi_run = 0;
  int   kfr = 0;
  bit   stop_stream = 1'b0;
  logic last_lock;
  logic [OUT_W-1:0] last_data;

  task automatic check(input bit ok, input string req,
                       input logic [OUT_W-1:0] act, input logic [OUT_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [OUT_W-1:0] rnd_word();
    logic [63:0] t;
    t = {$urandom(), $urandom()};
    return t[OUT_W-1:0];
  endfunction

  task automatic send_frame(input logic [OUT_W-1:0] w, input logic [WW-1:0] cp);
    for (int b = WW - 1; b >= 0; b--) begin
      @(negedge clk);
      if (b == WW - 1) begin
        last_lock = lock_o;
        last_data = data_o;
      end
      for (int i = 0; i < LANES; i++) lane_i[i] = w[i*WW + b];
      clk_lane_i = cp[b];
    end
  endtask

  // driver: push the expected word, then serialize
  task automatic good_frame(input logic [OUT_W-1:0] w);
    exp_q.push_back(kfr < 3 ? '0 : w);
    tag_q.push_back(kfr < 3 ? "R4" : (edge_sel_i ? "R2 R6" : "R2 R7"));
    kfr++;
    send_frame(w, PAT);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      lane_i = '0;
      clk_lane_i = 1'b0;
    end
  endtask

  task automatic stream(input logic [OUT_W-1:0] w);
    while (!stop_stream) send_frame(w, PAT);
  endtask

  // monitor: pop on each latching edge of pclk_o
  always @(negedge clk) begin
    if (mon_en) begin
      logic cur;
      logic [OUT_W-1:0] e;
      string t;
      cur = pclk_o;
      if (cur && !prev_pclk) begin
        hi_run = 1;
        if (edge_sel_i) begin
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected edge", data_o, '0);
          else begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(data_o == e, t, data_o, e);
          end
        end
      end else if (cur) begin
        hi_run++;
      end else if (prev_pclk) begin
        check(hi_run == 4, "R6 high time", OUT_W'(hi_run), OUT_W'(4));
        if (!edge_sel_i) begin
          if (exp_q.size() == 0) check(1'b0, "R3 unexpected edge", data_o, '0);
          else begin
            e = exp_q.pop_front(); t = tag_q.pop_front();
            check(data_o == e, t, data_o, e);
          end
        end
      end
      prev_pclk = cur;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; pd_ni = 1'b1; oe_i = 1'b1; edge_sel_i = 1'b1; test_i = 1'b0;
    clk_lane_i = 1'b0; lane_i = '0;
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(data_o == '0, "R1 data", data_o, '0);
    check(pclk_o == 1'b0, "R1 pclk", OUT_W'(pclk_o), '0);
    check(lock_o == 1'b0, "R1 lock", OUT_W'(lock_o), '0);

    // run A: rising edge, hunt through junk clock-lane bits first
    mon_en = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      lane_i = LANES'($urandom());
      clk_lane_i = (j != 1);
    end
    kfr = 0;
    for (int k = 0; k < 10; k++) begin
      good_frame(k == 0 ? 35'h4_0810_2041 : rnd_word());
      if (k == 0) check(last_lock == 1'b0, "R3 hunting", OUT_W'(last_lock), '0);
      if (k == 3) check(last_lock == 1'b0, "R4 lock after 3", OUT_W'(last_lock), '0);
      if (k == 4) check(last_lock == 1'b1, "R4 lock after 4", OUT_W'(last_lock), 1);
    end
    @(negedge clk);
    #1;
    mon_en = 1'b0;
    check(exp_q.size() == 0, "R6 all delivered", OUT_W'(exp_q.size()), '0);
    check(data_o != '0, "R6 last word shown", data_o, '1);
    pd_ni = 1'b0;
    lane_i = '0;
    clk_lane_i = 1'b0;
    #1;
    check(data_o == '0, "R9 data forced", data_o, '0);
    check(pclk_o == 1'b0, "R9 pclk held", OUT_W'(pclk_o), '0);
    idle(3);
    check(lock_o == 1'b0, "R9 lock cleared", OUT_W'(lock_o), '0);

    // run B: falling edge, test input high, one broken frame
    edge_sel_i = 1'b0;
    test_i = 1'b1;
    @(negedge clk);
    #1;
    pd_ni = 1'b1;
    prev_pclk = 1'b0;
    hi_run = 0;
    mon_en = 1'b1;
    kfr = 0;
    for (int k = 0; k < 6; k++) good_frame(rnd_word());
    send_frame(rnd_word(), 7'b0000000);
    kfr = 0;
    good_frame(rnd_word());
    check(last_lock == 1'b0, "R5 lock dropped", OUT_W'(last_lock), '0);
    check(last_data == '0, "R5 data cleared", last_data, '0);
    for (int k = 1; k < 8; k++) good_frame(rnd_word());
    idle(12);
    check(exp_q.size() == 0, "R7 R10 all delivered", OUT_W'(exp_q.size()), '0);
    #1;
    mon_en = 1'b0;
    test_i = 1'b0;

    // control truth table against a steady locked stream
    edge_sel_i = 1'b1;
    stop_stream = 1'b0;
    fork
      stream(HOLD);
    join_none
    repeat (70) @(negedge clk);
    for (int p = 1; p >= 0; p--) begin
      for (int o = 0; o < 2; o++) begin
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          #1;
          pd_ni = p[0]; oe_i = o[0]; edge_sel_i = s[0];
          #1;
          check(data_en_o == (o[0] ? '1 : '0), "R8 data enable", data_en_o, o[0] ? '1 : '0);
          check(pclk_en_o == o[0], "R8 pclk enable", OUT_W'(pclk_en_o), OUT_W'(o[0]));
          if (o[0] && p[0]) check(data_o == HOLD, "R8 data passes", data_o, HOLD);
          if (o[0] && !p[0]) begin
            check(data_o == '0, "R9 data zero", data_o, '0);
            check(pclk_o == 1'b0, "R9 pclk low", OUT_W'(pclk_o), '0);
          end
          if (p[0]) check(lock_o == 1'b1, "R8 lock kept", OUT_W'(lock_o), 1);
        end
      end
    end
    stop_stream = 1'b1;
    repeat (10) @(negedge clk);
    oe_i = 1'b1;
    pd_ni = 1'b1;
    repeat (3) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule